// File: doc/BRIEF.md
# Condition Flags and Branch Decision Unit

This block keeps the six status flags of an 8-bit processor core: half-carry, interrupt mask, negative, zero, overflow and carry. On each clock edge it takes flag results from the arithmetic unit, one write enable per flag. It also takes direct set and clear commands for carry, overflow and the interrupt mask. Outside the unit the flags are seen as a byte whose two top bits always read as one.

The unit also resolves conditional branches. A request carries a 4-bit condition code, the address of the branch instruction and a signed 8-bit displacement. The unit tests the condition against the flags and returns whether the branch is taken and the address of the next instruction. The condition codes come in complementary pairs on adjacent codes, and the low code bit inverts the test. The pairs cover single-flag tests, unsigned magnitude tests (carry OR zero) and signed two's-complement tests (negative XOR overflow, with or without zero).

Requests and responses are valid/ready streams. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. The result appears on the response port from the next cycle and stays there unchanged until `rsp_ready` takes it. The unit raises `req_ready` whenever its single result slot is empty or is being emptied in the same cycle, so back-pressure on the response side stalls the request side directly.

Top module: `ccr_branch_unit`

## Requirements
- R1: A synchronous reset sets the interrupt mask and clears all other flags, so `ccr_byte` reads 8'hD0 after reset.
- R2: `ccr_byte` holds, from bit 5 down to bit 0, H, I, N, Z, V, C. `alu_we`/`alu_flags` bit 4 is H, bit 3 N, bit 2 Z, bit 1 V and bit 0 C. A flag takes its `alu_flags` value only in a cycle where its `alu_we` bit is set, and holds otherwise.
- R3: `set_c`/`clr_c`, `set_v`/`clr_v` and `set_i`/`clr_i` force their flag to 1 or 0 and take priority over an ALU update of the same flag. When set and clear are given together, the flag clears.
- R4: `ccr_byte[7:6]` always reads 2'b11.
- R5: Single-flag codes: 4 taken when C=0, 5 when C=1, 6 when Z=0, 7 when Z=1, 8 when V=0, 9 when V=1, 10 when N=0, 11 when N=1.
- R6: Unsigned codes: 2 (higher) taken when (C OR Z)=0, 3 (lower or same) when (C OR Z)=1.
- R7: Signed codes: 12 taken when (N XOR V)=0, 13 when (N XOR V)=1, 14 when (Z OR (N XOR V))=0, 15 when (Z OR (N XOR V))=1.
- R8: Code 0 is always taken and code 1 is never taken. For every even code, the odd code above it gives the opposite decision.
- R9: A taken branch gives `rsp_next_pc` = `req_pc` + 2 + sign-extended `req_disp`, modulo 2^16.
- R10: A branch not taken gives `rsp_next_pc` = `req_pc` + 2, modulo 2^16.
- R11: `req_ready` is high exactly when no response is pending or the pending one is taken this cycle. Every accepted request yields one response in the following cycle, in order. A response held by `rsp_ready` low stays unchanged.
- R12: A request is evaluated against the flags held before the edge that accepts it. A flag update on that same edge does not affect the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_we | input | 5 | Per-flag write enables {H,N,Z,V,C} |
| alu_flags | input | 5 | Flag values from the ALU {H,N,Z,V,C} |
| set_c | input | 1 | Force carry to 1 |
| clr_c | input | 1 | Force carry to 0 |
| set_v | input | 1 | Force overflow to 1 |
| clr_v | input | 1 | Force overflow to 0 |
| set_i | input | 1 | Force interrupt mask to 1 |
| clr_i | input | 1 | Force interrupt mask to 0 |
| req_valid | input | 1 | Branch request present |
| req_ready | output | 1 | Branch request can be accepted |
| req_cond | input | 4 | Condition code |
| req_pc | input | 16 | Address of the branch instruction |
| req_disp | input | 8 | Signed displacement |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_taken | output | 1 | Branch decision |
| rsp_next_pc | output | 16 | Address of the next instruction |
| ccr_byte | output | 8 | Flag register as a byte |

## Verification
The hardest case to reach is a flag write that lands on the same edge that accepts a branch request. Only that case shows whether the decision uses the old flags or the new ones. It needs the result slot free, so that acceptance is immediate. The bench therefore switches off its random back-pressure and waits for the response queue to drain. It then drives the request and a full flag write in the same cycle, with new flags that flip the decision. The other branch tests sweep all sixteen N/Z/V/C patterns across all sixteen codes while `rsp_ready` toggles at random. This makes stalled responses and back-to-back acceptances common.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int FLAG_W    = 6;
  localparam int ALU_FLAGS = 5;
  localparam int COND_W    = 4;

  typedef struct packed {
    logic h;
    logic i;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // Condition pair index: req_cond[3:1]. Even code taken when raw test is 0.
  typedef enum logic [2:0] {
    PAIR_ALWAYS = 3'd0,
    PAIR_CZ     = 3'd1,
    PAIR_C      = 3'd2,
    PAIR_Z      = 3'd3,
    PAIR_V      = 3'd4,
    PAIR_N      = 3'd5,
    PAIR_NV     = 3'd6,
    PAIR_ZNV    = 3'd7
  } pair_e;

  localparam int NUM_PAIRS = 8;
endpackage

// File: rtl/ccr_flag_reg.sv
module ccr_flag_reg
  import ccr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ALU_FLAGS-1:0] alu_we,
  input  logic [ALU_FLAGS-1:0] alu_flags,
  input  logic                 set_c,
  input  logic                 clr_c,
  input  logic                 set_v,
  input  logic                 clr_v,
  input  logic                 set_i,
  input  logic                 clr_i,
  output ccr_t                 flags_q
);
  ccr_t flags_d;

  always_comb begin
    flags_d = flags_q;
    // ALU results, per-flag enables {H,N,Z,V,C}
    if (alu_we[4]) flags_d.h = alu_flags[4];
    if (alu_we[3]) flags_d.n = alu_flags[3];
    if (alu_we[2]) flags_d.z = alu_flags[2];
    if (alu_we[1]) flags_d.v = alu_flags[1];
    if (alu_we[0]) flags_d.c = alu_flags[0];
    // direct commands win over the ALU; clear wins over set
    if (set_c) flags_d.c = 1'b1;
    if (clr_c) flags_d.c = 1'b0;
    if (set_v) flags_d.v = 1'b1;
    if (clr_v) flags_d.v = 1'b0;
    if (set_i) flags_d.i = 1'b1;
    if (clr_i) flags_d.i = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '{i: 1'b1, default: 1'b0};
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/ccr_cond_eval.sv
module ccr_cond_eval
  import ccr_pkg::*;
(
  input  ccr_t              flags,
  input  logic [COND_W-1:0] cond,
  output logic              taken
);
  logic [NUM_PAIRS-1:0] raw;
  logic                 signed_lt;
  pair_e                pair;

  assign signed_lt = flags.n ^ flags.v;
  assign pair      = pair_e'(cond[COND_W-1:1]);

  always_comb begin
    raw              = '0;
    raw[PAIR_ALWAYS] = 1'b0;
    raw[PAIR_CZ]     = flags.c | flags.z;
    raw[PAIR_C]      = flags.c;
    raw[PAIR_Z]      = flags.z;
    raw[PAIR_V]      = flags.v;
    raw[PAIR_N]      = flags.n;
    raw[PAIR_NV]     = signed_lt;
    raw[PAIR_ZNV]    = flags.z | signed_lt;
  end

  // even code: taken when raw is 0; odd code: taken when raw is 1
  assign taken = (raw[pair] == cond[0]);
endmodule

// File: rtl/ccr_target_adder.sv
module ccr_target_adder #(
  parameter int ADDR_W   = 16,
  parameter int DISP_W   = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_LEN);

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign offset = disp[ADDR_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + STEP;
  assign next_pc = taken ? seq_pc + offset : seq_pc;
endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit
  import ccr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DISP_W   = 8,
  parameter int INSN_LEN = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ALU_FLAGS-1:0] alu_we,
  input  logic [ALU_FLAGS-1:0] alu_flags,
  input  logic                 set_c,
  input  logic                 clr_c,
  input  logic                 set_v,
  input  logic                 clr_v,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [COND_W-1:0]    req_cond,
  input  logic [ADDR_W-1:0]    req_pc,
  input  logic [DISP_W-1:0]    req_disp,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_taken,
  output logic [ADDR_W-1:0]    rsp_next_pc,
  output logic [7:0]           ccr_byte
);
  ccr_t              flags_q;
  logic              eval_taken;
  logic [ADDR_W-1:0] eval_pc;
  logic              accept;

  ccr_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .alu_we    (alu_we),
    .alu_flags (alu_flags),
    .set_c     (set_c),
    .clr_c     (clr_c),
    .set_v     (set_v),
    .clr_v     (clr_v),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .flags_q   (flags_q)
  );

  ccr_cond_eval u_eval (
    .flags (flags_q),
    .cond  (req_cond),
    .taken (eval_taken)
  );

  ccr_target_adder #(
    .ADDR_W   (ADDR_W),
    .DISP_W   (DISP_W),
    .INSN_LEN (INSN_LEN)
  ) u_target (
    .pc      (req_pc),
    .disp    (req_disp),
    .taken   (eval_taken),
    .next_pc (eval_pc)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_taken   <= 1'b0;
      rsp_next_pc <= '0;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (accept) begin
        rsp_taken   <= eval_taken;
        rsp_next_pc <= eval_pc;
      end
    end
  end

  assign ccr_byte = {2'b11, flags_q};
endmodule

// File: rtl/ccr_branch_unit_chk.sv
module ccr_branch_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        alu_we,
  input logic              set_c,
  input logic              clr_c,
  input logic              set_v,
  input logic              clr_v,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_taken,
  input logic [ADDR_W-1:0] rsp_next_pc,
  input logic [7:0]        ccr_byte
);
  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> ccr_byte == 8'hD0);

  p_hold_n_r2: assert property (@(posedge clk) disable iff (rst)
    !alu_we[3] |=> ccr_byte[3] == $past(ccr_byte[3]));

  p_hold_z_r2: assert property (@(posedge clk) disable iff (rst)
    !alu_we[2] |=> ccr_byte[2] == $past(ccr_byte[2]));

  p_clear_c_r3: assert property (@(posedge clk) disable iff (rst)
    clr_c |=> !ccr_byte[0]);

  p_set_v_r3: assert property (@(posedge clk) disable iff (rst)
    (set_v && !clr_v) |=> ccr_byte[1]);

  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_taken) && $stable(rsp_next_pc)));

  p_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind ccr_branch_unit ccr_branch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .alu_we      (alu_we),
  .set_c       (set_c),
  .clr_c       (clr_c),
  .set_v       (set_v),
  .clr_v       (clr_v),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_taken   (rsp_taken),
  .rsp_next_pc (rsp_next_pc),
  .ccr_byte    (ccr_byte)
);

// File: tb/ccr_branch_unit_test.sv
module ccr_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  alu_we = '0, alu_flags = '0;
  logic        set_c = 0, clr_c = 0, set_v = 0, clr_v = 0, set_i = 0, clr_i = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [3:0]  req_cond = '0;
  logic [15:0] req_pc = '0;
  logic [7:0]  req_disp = '0;
  logic        rsp_valid, rsp_taken;
  logic        rsp_ready = 0;
  logic [15:0] rsp_next_pc;
  logic [7:0]  ccr_byte;

  typedef struct { logic taken; logic [15:0] npc; string tag; } exp_t;
  exp_t        scb[$];
  int          n_checks = 0, n_fail = 0;
  logic [5:0]  model = 6'h10;   // {H,I,N,Z,V,C}
  logic        bp_on = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  bit          done = 0;

  always #5 clk = ~clk;

  ccr_branch_unit uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cond_ok(input logic [3:0] code, input logic [5:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (code)
      4'd0: cond_ok = 1'b1;          4'd1: cond_ok = 1'b0;
      4'd2: cond_ok = !(c | z);      4'd3: cond_ok = c | z;
      4'd4: cond_ok = !c;            4'd5: cond_ok = c;
      4'd6: cond_ok = !z;            4'd7: cond_ok = z;
      4'd8: cond_ok = !v;            4'd9: cond_ok = v;
      4'd10: cond_ok = !n;           4'd11: cond_ok = n;
      4'd12: cond_ok = !(n ^ v);     4'd13: cond_ok = n ^ v;
      4'd14: cond_ok = !(z | (n ^ v));
      default: cond_ok = z | (n ^ v);
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    if (code < 2) return "R8";
    if (code < 4) return "R6";
    if (code < 12) return "R5";
    return "R7";
  endfunction

  // driver: pushes expected result, then offers the request
  task automatic branch(input logic [3:0] code, input logic [15:0] pc, input logic [7:0] disp,
                        input bit upd, input logic [5:0] newf, input string tag);
    exp_t e;
    e.taken = cond_ok(code, model);
    e.npc   = pc + 16'd2 + (e.taken ? {{8{disp[7]}}, disp} : 16'd0);
    e.tag   = tag;
    scb.push_back(e);
    @(posedge clk); #2;
    req_valid = 1; req_cond = code; req_pc = pc; req_disp = disp;
    if (upd) begin
      alu_we = 5'h1F;
      alu_flags = {newf[5], newf[3:0]};
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 0; alu_we = '0;
    if (upd) model = {newf[5], model[4], newf[3:0]};
  endtask

  task automatic load_flags(input logic [5:0] f);
    @(posedge clk); #2;
    alu_we = 5'h1F; alu_flags = {f[5], f[3:0]};
    set_i = f[4]; clr_i = !f[4];
    @(posedge clk); #2;
    alu_we = '0; set_i = 0; clr_i = 0;
    model = f;
  endtask

  task automatic drain;
    while (scb.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  // response ready pattern
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (!rst && rsp_valid && rsp_ready) begin
      if (scb.size() == 0) check(0, "R11 unexpected response", 32'(rsp_next_pc), 0);
      else begin
        exp_t e;
        e = scb.pop_front();
        check(rsp_taken == e.taken, {e.tag, " taken"}, 32'(rsp_taken), 32'(e.taken));
        check(rsp_next_pc == e.npc, {e.tag, " next_pc"}, 32'(rsp_next_pc), 32'(e.npc));
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    check(ccr_byte == 8'hD0, "R1 R4 reset value", 32'(ccr_byte), 32'hD0);

    // R2: partial ALU enables, only N and V written
    @(posedge clk); #2; alu_we = 5'b01010; alu_flags = 5'b11111;
    @(posedge clk); #2; alu_we = '0;
    @(negedge clk);
    check(ccr_byte == 8'hDA, "R2 partial enables", 32'(ccr_byte), 32'hDA);

    // R3: set carry over ALU clearing it; clear mask
    @(posedge clk); #2; alu_we = 5'b00001; alu_flags = 5'b00000; set_c = 1; clr_i = 1;
    @(posedge clk); #2; alu_we = '0; set_c = 0; clr_i = 0;
    @(negedge clk);
    check(ccr_byte == 8'hCB, "R3 direct over ALU", 32'(ccr_byte), 32'hCB);

    // R3: set and clear together -> clear
    @(posedge clk); #2; set_v = 1; clr_v = 1;
    @(posedge clk); #2; set_v = 0; clr_v = 0;
    @(negedge clk);
    check(ccr_byte == 8'hC9, "R3 clear wins", 32'(ccr_byte), 32'hC9);
    check(ccr_byte[7:6] == 2'b11, "R4 top bits", 32'(ccr_byte[7:6]), 32'h3);

    // R5..R8: every N/Z/V/C pattern against every code, under back-pressure
    bp_on = 1;
    for (int p = 0; p < 16; p++) begin
      drain();
      load_flags({1'b0, 1'b1, 4'(p)});
      for (int k = 0; k < 16; k++)
        branch(4'(k), 16'(p * 16'h1111 + k), 8'(k * 37 + p), 0, '0, tag_of(4'(k)));
    end

    // R9/R10 address wrap
    drain();
    load_flags(6'h04);  // Z=1
    branch(4'd7, 16'hFFFF, 8'h05, 0, '0, "R9 wrap up");
    branch(4'd7, 16'h0001, 8'h80, 0, '0, "R9 wrap down");
    branch(4'd6, 16'hFFFE, 8'h7F, 0, '0, "R10 wrap");
    branch(4'd1, 16'h1234, 8'hF0, 0, '0, "R10 never");

    // R12: flag write on the accepting edge uses old flags
    drain();
    bp_on = 0;
    repeat (2) @(posedge clk);
    branch(4'd7, 16'h4000, 8'h10, 1, 6'h00, "R12 old Z=1");   // taken with old Z=1
    drain();
    branch(4'd7, 16'h4000, 8'h10, 0, '0, "R12 new Z=0");       // now not taken
    drain();
    @(negedge clk);
    check(ccr_byte == 8'hC0, "R12 flags written", 32'(ccr_byte), 32'hC0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule